// File: doc/BRIEF.md
# Six-Mode Programmable Down-Counter Timer

A single timer channel built around a 16-bit down-counter. It has a count input (`cnt_in`), a gate input (`gate_in`) and one waveform output (`tmr_out`). The count input is sampled in the system clock domain. Each rising edge seen on it is one count event. A host selects the operating mode by writing a control byte, then writes a 16-bit starting count as two bytes. It can read the live counter value at any time. The six modes are event counting, retriggerable one-shot, rate generation (divide-by-N), square wave, software-started strobe and gate-started strobe.

The control byte carries the mode number in bits 3:1. A byte is accepted only if its upper nibble is `0011` and bit 0 is clear. Accepting a byte parks the counter in an idle state, with the output at the mode's resting level, until a full count has been written. The triggered modes (one-shot and gate-started strobe) then wait for a rising gate edge. The other modes start counting as soon as the high byte lands.

Internally a state machine moves through four named states. ST_IDLE means no count has been loaded yet. ST_ARMED means a count is held and a gate edge is awaited. ST_RUN means counting. ST_DONE means the one-shot or strobe has finished. The named transitions are:
- LOAD: IDLE to RUN in the untriggered modes.
- ARM: IDLE to ARMED in the triggered modes.
- FIRE: ARMED to RUN on a gate edge.
- EXPIRE: RUN to DONE when the count leaves 1 in modes 0, 1, 4 and 5.
- RETRIGGER: RUN or DONE back to RUN on a gate edge in the triggered modes.
- RELOAD: RUN to RUN when the count leaves 1 in modes 2 and 3.
- STOP: any state to IDLE on an accepted control byte.

Top module: `prog_down_timer`

## Requirements
- R1: A control byte is accepted only when bits 7:4 equal 4'b0011, bit 0 is 0 and the mode field in bits 3:1 is 0 to 5, so 0x30/0x32/0x34/0x36/0x38/0x3A select modes 0..5. Any other byte written to the control port has no effect on the counter, the state or the output.
- R2: An accepted control byte stops counting and holds the counter value. The output goes low in mode 0 and high in modes 1 to 5, and stays there until a full count is loaded.
- R3: The count is written low byte first, then high byte (value = high*256 + low). Nothing changes until the high byte is written, and the counter then holds the new value one clock later.
- R4: Mode 0: the output is low while counting. The counter decrements per count event, and when it reaches 0 the output goes high and counting stops at 0.
- R5: Mode 1: after a load the output stays high and the count does not move. A gate rising edge reloads the count and drives the output low. The output returns high when the count reaches 0. Any later gate rising edge retriggers from the loaded value.
- R6: Mode 2: the output is high except while the count equals 1. The count event that finds the count at 1 reloads the loaded value.
- R7: Mode 3: with loaded value N, the output is high while the count is above floor(N/2) and low otherwise, and the counter reloads N after 1. The high phase is therefore one event longer than the low phase when N is odd.
- R8: Mode 4: loading the count starts counting with the output high. The output is low only while the count equals 1. When the count reaches 0 the output returns high and counting stops.
- R9: Mode 5: counting as in mode 4, but started by a gate rising edge after the load rather than by the load. A further gate rising edge restarts it.
- R10: In modes 0, 2, 3 and 4 a low gate level suspends counting. In modes 1 and 5 the gate level does not affect counting.
- R11: A count event is a low-to-high transition of `cnt_in` seen between two clock edges. An input held high counts once.
- R12: `count_value` shows the live counter while it runs. After reset the mode is 0, the state is idle, the counter is 0 and the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control byte write strobe |
| cnt_wr | input | 1 | Count byte write strobe (low byte, then high byte) |
| wr_data | input | 8 | Write data for both strobes |
| cnt_in | input | 1 | Count input, one event per rising edge |
| gate_in | input | 1 | Gate: level enable or edge trigger, by mode |
| count_value | output | 16 | Live counter value |
| tmr_out | output | 1 | Timer waveform output |

## Verification
The assertions assume that `cnt_in` and `gate_in` are already synchronous to `clk`. They also assume the two write strobes are single-cycle pulses, and that a loaded value of 1 is never used in modes 2 and 3. The stimulus changes every input only on the falling clock edge, and holds each strobe and each count pulse for exactly one cycle. It loads only counts of 2 or more in the periodic modes. Gate edges in level-enabled modes and count edges in idle states are applied on purpose, to show that they are ignored rather than to exercise undefined cases.

// File: rtl/timer_pkg.sv
package timer_pkg;
    typedef enum logic [2:0] {
        MD_EVENT    = 3'd0,
        MD_ONESHOT  = 3'd1,
        MD_RATE     = 3'd2,
        MD_SQUARE   = 3'd3,
        MD_SWSTROBE = 3'd4,
        MD_HWSTROBE = 3'd5
    } mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2,
        ST_DONE  = 2'd3
    } tstate_e;

    localparam logic [3:0] CTL_TAG = 4'b0011;
endpackage

// File: rtl/tmr_edge.sv
module tmr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic rise
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sig;
    end

    assign rise = sig & ~prev_q;
endmodule

// File: rtl/tmr_host_regs.sv
module tmr_host_regs
    import timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctl_wr,
    input  logic                cnt_wr,
    input  logic [CNT_W/2-1:0]  wr_data,
    output mode_e               mode,
    output logic                ctl_acc,
    output logic                ld_pulse,
    output logic [CNT_W-1:0]    ld_val
);
    localparam int BYTE_W = CNT_W / 2;

    logic              hi_next_q;
    logic [BYTE_W-1:0] lsb_q;
    logic [2:0]        mode_field;

    assign mode_field = wr_data[3:1];
    assign ctl_acc    = ctl_wr && (wr_data[7:4] == CTL_TAG) && !wr_data[0]
                        && (mode_field <= 3'd5);
    assign ld_pulse   = cnt_wr && hi_next_q && !ctl_acc;
    assign ld_val     = {wr_data, lsb_q};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode      <= MD_EVENT;
            hi_next_q <= 1'b0;
            lsb_q     <= '0;
        end else if (ctl_acc) begin
            mode      <= mode_e'(mode_field);
            hi_next_q <= 1'b0;
        end else if (cnt_wr) begin
            if (!hi_next_q) lsb_q <= wr_data;
            hi_next_q <= ~hi_next_q;
        end
    end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  mode_e            mode,
    input  logic             ctl_acc,
    input  logic             ld_pulse,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             tick,
    input  logic             gate_lvl,
    input  logic             gate_rise,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] init,
    output tstate_e          state,
    output logic             tmr_out
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    tstate_e          state_nx;
    logic [CNT_W-1:0] count_nx, init_nx, half;
    logic             is_trig, cnt_en, periodic;

    assign is_trig  = (mode == MD_ONESHOT) || (mode == MD_HWSTROBE);
    assign periodic = (mode == MD_RATE) || (mode == MD_SQUARE);
    assign cnt_en   = tick && (is_trig || gate_lvl);
    assign half     = init >> 1;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            count <= '0;
            init  <= '0;
        end else begin
            state <= state_nx;
            count <= count_nx;
            init  <= init_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        count_nx = count;
        init_nx  = init;
        if (ctl_acc) begin
            state_nx = ST_IDLE;                          // STOP
        end else if (ld_pulse) begin
            init_nx = ld_val;
            if (is_trig) begin
                if (state == ST_IDLE) state_nx = ST_ARMED; // ARM
            end else begin
                count_nx = ld_val;                       // LOAD
                state_nx = ST_RUN;
            end
        end else begin
            unique case (state)
                ST_IDLE: ;
                ST_ARMED: begin
                    if (gate_rise) begin                 // FIRE
                        count_nx = init;
                        state_nx = ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (is_trig && gate_rise) begin      // RETRIGGER
                        count_nx = init;
                    end else if (cnt_en) begin
                        if (count == ONE) begin
                            if (periodic) count_nx = init;     // RELOAD
                            else begin
                                count_nx = '0;                 // EXPIRE
                                state_nx = ST_DONE;
                            end
                        end else begin
                            count_nx = count - ONE;
                        end
                    end
                end
                ST_DONE: begin
                    if (is_trig && gate_rise) begin      // RETRIGGER
                        count_nx = init;
                        state_nx = ST_RUN;
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (mode)
            MD_EVENT:    tmr_out = (state == ST_DONE);
            MD_ONESHOT:  tmr_out = (state != ST_RUN);
            MD_RATE:     tmr_out = !((state == ST_RUN) && (count == ONE));
            MD_SQUARE:   tmr_out = !((state == ST_RUN) && (count <= half));
            MD_SWSTROBE,
            MD_HWSTROBE: tmr_out = !((state == ST_RUN) && (count == ONE));
            default:     tmr_out = 1'b1;
        endcase
    end
endmodule

// File: rtl/prog_down_timer.sv
module prog_down_timer
    import timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctl_wr,
    input  logic               cnt_wr,
    input  logic [CNT_W/2-1:0] wr_data,
    input  logic               cnt_in,
    input  logic               gate_in,
    output logic [CNT_W-1:0]   count_value,
    output logic               tmr_out
);
    mode_e            mode;
    tstate_e          state;
    logic             ctl_acc, ld_pulse, tick, gate_rise;
    logic [CNT_W-1:0] ld_val, init;

    tmr_edge u_cnt_edge  (.clk(clk), .rst_n(rst_n), .sig(cnt_in),  .rise(tick));
    tmr_edge u_gate_edge (.clk(clk), .rst_n(rst_n), .sig(gate_in), .rise(gate_rise));

    tmr_host_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .cnt_wr(cnt_wr),
        .wr_data(wr_data), .mode(mode), .ctl_acc(ctl_acc),
        .ld_pulse(ld_pulse), .ld_val(ld_val)
    );

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .mode(mode), .ctl_acc(ctl_acc),
        .ld_pulse(ld_pulse), .ld_val(ld_val), .tick(tick),
        .gate_lvl(gate_in), .gate_rise(gate_rise), .count(count_value),
        .init(init), .state(state), .tmr_out(tmr_out)
    );
endmodule

// File: rtl/prog_down_timer_chk.sv
module prog_down_timer_chk
    import timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             gate_lvl,
    input logic             gate_rise,
    input logic             ld_pulse,
    input logic             ctl_acc,
    input mode_e            mode,
    input tstate_e          state,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] init,
    input logic             tmr_out
);
    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !ld_pulse && !gate_rise) |=> $stable(count)); // R11
    AST_CTL_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_acc |=> (state == ST_IDLE)); // R2
    AST_EVENT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_EVENT && state != ST_DONE) |-> !tmr_out); // R4
    AST_ONESHOT_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_ONESHOT && gate_rise && !ld_pulse && !ctl_acc && state != ST_IDLE)
        |=> (!tmr_out && count == $past(init))); // R5
    AST_RATE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_RATE && state == ST_RUN && tick && gate_lvl && count == 1
         && !ld_pulse && !ctl_acc) |=> (count == $past(init))); // R6
    AST_GATE_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode inside {MD_EVENT, MD_RATE, MD_SQUARE, MD_SWSTROBE}) && !gate_lvl
         && !ld_pulse && !ctl_acc) |=> $stable(count)); // R10
    AST_STROBE_DONE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MD_SWSTROBE || mode == MD_HWSTROBE) && state == ST_DONE) |-> tmr_out); // R8
    AST_ARMED_TRIG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED) |-> (mode == MD_ONESHOT || mode == MD_HWSTROBE)); // R9
endmodule

bind prog_down_timer prog_down_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .gate_lvl(gate_in),
    .gate_rise(gate_rise), .ld_pulse(ld_pulse), .ctl_acc(ctl_acc),
    .mode(mode), .state(state), .count(count_value), .init(init),
    .tmr_out(tmr_out)
);

// File: tb/prog_down_timer_tb.sv
module prog_down_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0, cnt_wr = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic        cnt_in = 1'b0, gate_in = 1'b1;
    logic [15:0] count_value;
    logic        tmr_out;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct {
        logic [15:0] cnt;
        logic        out;
        string       req;
    } exp_t;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    prog_down_timer u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .cnt_wr(cnt_wr),
        .wr_data(wr_data), .cnt_in(cnt_in), .gate_in(gate_in),
        .count_value(count_value), .tmr_out(tmr_out)
    );

    // monitor: compares the front of the scoreboard with the outputs
    initial begin
        forever begin
            wait (sb_q.size() != 0);
            #1;
            checks++;
            if (count_value !== sb_q[0].cnt || tmr_out !== sb_q[0].out) begin
                errors++;
                $display("FAIL %s: count=%0h out=%0b expected count=%0h out=%0b",
                         sb_q[0].req, count_value, tmr_out, sb_q[0].cnt, sb_q[0].out);
            end
            void'(sb_q.pop_front());
        end
    end

    task automatic expect_st(input logic [15:0] c, input logic o, input string r);
        exp_t e;
        e.cnt = c; e.out = o; e.req = r;
        sb_q.push_back(e);
        wait (sb_q.size() == 0);
    endtask

    task automatic wr_ctl(input logic [7:0] b);
        @(negedge clk); ctl_wr = 1'b1; wr_data = b;
        @(negedge clk); ctl_wr = 1'b0;
    endtask

    task automatic wr_cnt(input logic [7:0] b);
        @(negedge clk); cnt_wr = 1'b1; wr_data = b;
        @(negedge clk); cnt_wr = 1'b0;
    endtask

    task automatic load16(input logic [15:0] v);
        wr_cnt(v[7:0]);
        wr_cnt(v[15:8]);
    endtask

    task automatic pulse();
        @(negedge clk); cnt_in = 1'b1;
        @(negedge clk); cnt_in = 1'b0;
    endtask

    task automatic gate_edge();
        @(negedge clk); gate_in = 1'b0;
        @(negedge clk); gate_in = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: count=%0h out=%0b expected completion", count_value, tmr_out);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_st(16'h0000, 1'b0, "R12 reset");

        // mode 0
        wr_ctl(8'h30);      expect_st(16'h0000, 1'b0, "R2 mode0 idle");
        wr_cnt(8'h05);      expect_st(16'h0000, 1'b0, "R3 low byte only");
        pulse();            expect_st(16'h0000, 1'b0, "R3 no count before high byte");
        wr_cnt(8'h00);      expect_st(16'h0005, 1'b0, "R3 loaded");
        pulse();            expect_st(16'h0004, 1'b0, "R4");
        pulse();            expect_st(16'h0003, 1'b0, "R4");
        @(negedge clk); cnt_in = 1'b1;
        repeat (4) @(negedge clk);
        cnt_in = 1'b0;      expect_st(16'h0002, 1'b0, "R11 held input counts once");
        pulse();            expect_st(16'h0001, 1'b0, "R4");
        @(negedge clk); gate_in = 1'b0;
        pulse();            expect_st(16'h0001, 1'b0, "R10 gate low mode0");
        @(negedge clk); gate_in = 1'b1;
        pulse();            expect_st(16'h0000, 1'b1, "R4 terminal");
        pulse();            expect_st(16'h0000, 1'b1, "R4 stops at 0");

        wr_ctl(8'h30);      expect_st(16'h0000, 1'b0, "R2 mode0 rewrite");
        load16(16'h0107);   expect_st(16'h0107, 1'b0, "R3 byte order");
        pulse();            expect_st(16'h0106, 1'b0, "R12 live read");

        // mode 1
        wr_ctl(8'h32);      expect_st(16'h0106, 1'b1, "R2 mode1 idle");
        load16(16'h0003);   expect_st(16'h0106, 1'b1, "R5 armed");
        pulse();            expect_st(16'h0106, 1'b1, "R5 no count while armed");
        gate_edge();        expect_st(16'h0003, 1'b0, "R5 fire");
        pulse();            expect_st(16'h0002, 1'b0, "R5");
        gate_edge();        expect_st(16'h0003, 1'b0, "R5 retrigger");
        pulse();            expect_st(16'h0002, 1'b0, "R5");
        pulse();            expect_st(16'h0001, 1'b0, "R5");
        pulse();            expect_st(16'h0000, 1'b1, "R5 end");
        gate_edge();        expect_st(16'h0003, 1'b0, "R5 retrigger after end");
        @(negedge clk); gate_in = 1'b0;
        pulse();            expect_st(16'h0002, 1'b0, "R10 gate level ignored mode1");
        pulse();            expect_st(16'h0001, 1'b0, "R5");
        pulse();            expect_st(16'h0000, 1'b1, "R5 end");

        // mode 2
        wr_ctl(8'h34);
        @(negedge clk); gate_in = 1'b1;
        expect_st(16'h0000, 1'b1, "R2 mode2 idle");
        load16(16'h0003);   expect_st(16'h0003, 1'b1, "R6 load");
        pulse();            expect_st(16'h0002, 1'b1, "R6");
        pulse();            expect_st(16'h0001, 1'b0, "R6 low at 1");
        pulse();            expect_st(16'h0003, 1'b1, "R6 reload");
        @(negedge clk); gate_in = 1'b0;
        pulse();            expect_st(16'h0003, 1'b1, "R10 gate low mode2");
        @(negedge clk); gate_in = 1'b1;
        pulse();            expect_st(16'h0002, 1'b1, "R6 resume");

        // mode 3
        wr_ctl(8'h36);      expect_st(16'h0002, 1'b1, "R2 mode3 idle");
        load16(16'h0005);   expect_st(16'h0005, 1'b1, "R7 odd load");
        pulse();            expect_st(16'h0004, 1'b1, "R7 odd high");
        pulse();            expect_st(16'h0003, 1'b1, "R7 odd high extra");
        pulse();            expect_st(16'h0002, 1'b0, "R7 odd low");
        pulse();            expect_st(16'h0001, 1'b0, "R7 odd low");
        pulse();            expect_st(16'h0005, 1'b1, "R7 odd reload");
        load16(16'h0004);   expect_st(16'h0004, 1'b1, "R7 even load");
        pulse();            expect_st(16'h0003, 1'b1, "R7 even high");
        pulse();            expect_st(16'h0002, 1'b0, "R7 even low");
        pulse();            expect_st(16'h0001, 1'b0, "R7 even low");
        pulse();            expect_st(16'h0004, 1'b1, "R7 even reload");

        // mode 4
        wr_ctl(8'h38);      expect_st(16'h0004, 1'b1, "R2 mode4 idle");
        load16(16'h0003);   expect_st(16'h0003, 1'b1, "R8 load starts");
        pulse();            expect_st(16'h0002, 1'b1, "R8");
        pulse();            expect_st(16'h0001, 1'b0, "R8 strobe");
        pulse();            expect_st(16'h0000, 1'b1, "R8 after strobe");
        pulse();            expect_st(16'h0000, 1'b1, "R8 stopped");

        // mode 5
        wr_ctl(8'h3A);      expect_st(16'h0000, 1'b1, "R2 mode5 idle");
        load16(16'h0002);   expect_st(16'h0000, 1'b1, "R9 armed");
        pulse();            expect_st(16'h0000, 1'b1, "R9 no count while armed");
        gate_edge();        expect_st(16'h0002, 1'b1, "R9 fire");
        pulse();            expect_st(16'h0001, 1'b0, "R9 strobe");
        pulse();            expect_st(16'h0000, 1'b1, "R9 after strobe");
        gate_edge();        expect_st(16'h0002, 1'b1, "R9 restart");

        // control byte filtering
        wr_ctl(8'h3C);      expect_st(16'h0002, 1'b1, "R1 mode6 ignored");
        pulse();            expect_st(16'h0001, 1'b0, "R1 still running");
        pulse();            expect_st(16'h0000, 1'b1, "R1 still mode5");
        wr_ctl(8'h20);      expect_st(16'h0000, 1'b1, "R1 bad upper nibble");
        wr_ctl(8'h31);      expect_st(16'h0000, 1'b1, "R1 bit0 set");
        wr_ctl(8'h3E);      expect_st(16'h0000, 1'b1, "R1 mode7 ignored");
        wr_ctl(8'h30);      expect_st(16'h0000, 1'b0, "R1 valid accepted");

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule